// File: doc/BRIEF.md
# I2C Channel-Select Target

This block is a small I2C target that holds a single control byte and uses it to switch up to four downstream bus segments on or off. It receives the bus clock and data lines as plain inputs, cleans them up inside the system clock domain, and pulls its data output low whenever it acknowledges a byte or returns a zero bit during a read. The open-drain wiring of that output to the shared data line is left to the chip top.

A controller selects channels by writing one data byte after the address byte. The new selection reaches the enable outputs only when the controller ends the transfer with a stop condition. This means a segment is never switched while the bus is in the middle of a transfer. A read returns the live per-channel interrupt status in the upper half of the byte and the channel enables that are currently applied in the lower half. The controller can use that byte to find which segment raised an interrupt.

Top module: `chsel_i2c_target`

## Requirements
- R1: The target answers to the 7-bit address {ADDR_HI, addr_pins}, where ADDR_HI defaults to 5'b11100. After the eighth bit of a matching address byte it holds sda_drive_low high for the whole ninth clock. Bit 0 of the address byte selects the direction: 1 is a read and 0 is a write.
- R2: When the address does not match, the target never drives SDA until the next stop. The channel enables are left unchanged.
- R3: In a write, bits 3..0 of each data byte, with bit 0 for channel 0, become the pending channel selection. When several data bytes arrive in one transfer, the last one wins. Any pattern from 0 to 15 is legal.
- R4: Bits 7..4 of a written data byte have no effect on the enables.
- R5: ch_en changes only in the cycle after a stop has been detected. Before that stop it keeps its previous value, including across a repeated start.
- R6: A read byte is sent MSB first. Bit 4+i is 1 when irq_n[i] is low. Bits 3..0 equal ch_en.
- R7: During a read, an acknowledge from the controller (SDA low on the ninth clock) starts another byte with the interrupt status sampled again. A not-acknowledge (SDA high) makes the target release SDA and ignore the bus until the next stop.
- R8: Every data byte received after a matching write address is acknowledged.
- R9: A repeated start at any point restarts address reception, so the direction can change without a stop.
- R10: While rst_n is low (synchronous), ch_en is 0 and SDA is released. After rst_n returns high, the target is idle.
- R11: A pulse on SCL or SDA that lasts fewer than FILT_CYCLES system clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| addr_pins | input | 2 | Strapped low address bits |
| irq_n | input | 4 | Active-low interrupt inputs, one per channel |
| sda_drive_low | output | 1 | 1 = pull the data line low |
| ch_en | output | 4 | Applied channel enables, bit i for channel i |

## Verification
The bench covers these cases:
- **Address matching:** all 16 pairings of strapped pins against the address bits that are sent. This separates a correct match from one that ignores the pins or the fixed upper part.
- **Write and read sweep:** all 16 channel patterns are written with a scrambled upper nibble, then read back with a rotated interrupt pattern. This shows whether a nibble is swapped, inverted or leaks from the upper bits.
- **Transfer sequences:** multi-byte writes, multi-byte reads with ack and with nack, and a repeated start between a write and a read. These confirm that the enables wait for the stop and that the status is sampled again for each byte.
- **Glitches and reset:** a write with short spikes injected on both lines, and a reset in the middle of a transfer. These check the filter and the reset behaviour.

// File: rtl/chsel_pkg.sv
// Shared definitions for the channel-select I2C target.
package chsel_pkg;

    // Protocol state of the target.
    typedef enum logic [2:0] {
        ST_IDLE,      // waiting for a start
        ST_ADDR,      // shifting in the address byte
        ST_ADDR_ACK,  // acknowledging a matched address
        ST_WDATA,     // shifting in a write data byte
        ST_WACK,      // acknowledging a write data byte
        ST_RDATA,     // shifting out a read data byte
        ST_RACK,      // sampling the controller's ack or nack
        ST_SKIP       // not addressed or nacked: wait for stop
    } tgt_state_e;

endpackage

// File: rtl/chsel_line_filter.sv
// Synchronizes one asynchronous bus line and rejects pulses shorter than
// FILT_CYCLES clocks. Assumes the line idles high, so every flop resets to 1.
module chsel_line_filter #(
    parameter int FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic clean_out
);
    localparam int CNT_W = $clog2(FILT_CYCLES + 1);

    logic             meta_q;
    logic             sync_q;
    logic [CNT_W-1:0] hold_cnt;

    // Two-flop synchronizer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= raw_in;
            sync_q <= meta_q;
        end
    end

    // Accept a new level only after it has held for FILT_CYCLES clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_out <= 1'b1;
            hold_cnt  <= '0;
        end else if (sync_q != clean_out) begin
            if (hold_cnt == CNT_W'(FILT_CYCLES - 1)) begin
                clean_out <= sync_q;
                hold_cnt  <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end else begin
            hold_cnt <= '0;
        end
    end
endmodule

// File: rtl/chsel_bus_events.sv
// Turns the filtered SCL and SDA lines into single-cycle start, stop and
// clock-edge pulses. Assumes both inputs are already clean and synchronous.
module chsel_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_q;
    logic sda_q;

    // Remember the previous line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // SDA edges while SCL stays high are bus conditions; SCL edges are clocks.
    always_comb begin
        start_o = scl_f & scl_q & sda_q & ~sda_f;
        stop_o  = scl_f & scl_q & ~sda_q & sda_f;
        rise_o  = scl_f & ~scl_q;
        fall_o  = ~scl_f & scl_q;
    end
endmodule

// File: rtl/chsel_target_fsm.sv
// Byte-level protocol engine: address match, acknowledge, write capture,
// read shift-out, and channel-enable commit on stop. Assumes single-cycle
// event pulses from chsel_bus_events; start and stop win over clock edges.
module chsel_target_fsm
    import chsel_pkg::*;
#(
    parameter int                    NCH        = 4,
    parameter int                    ADDR_PIN_W = 2,
    parameter logic [6-ADDR_PIN_W:0] ADDR_HI    = 5'b11100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  stop_i,
    input  logic                  rise_i,
    input  logic                  fall_i,
    input  logic                  sda_i,
    input  logic [ADDR_PIN_W-1:0] addr_pins,
    input  logic [NCH-1:0]        irq_n,
    output logic [NCH-1:0]        ch_en,
    output logic                  sda_drive_low,
    output tgt_state_e            state_o,
    output logic [3:0]            bit_cnt_o
);
    localparam int BYTE_W = 2 * NCH;

    tgt_state_e        state;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              is_read;
    logic              ctl_acked;
    logic [NCH-1:0]    pend_sel;
    logic              pend_vld;
    logic [NCH-1:0]    sel_q;
    logic [NCH-1:0]    irq_m;
    logic [NCH-1:0]    irq_s;
    logic [6:0]        own_addr;
    logic [BYTE_W-1:0] rd_byte;
    logic              byte_done;

    // Interrupt inputs are asynchronous: bring them into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_m <= '1;
            irq_s <= '1;
        end else begin
            irq_m <= irq_n;
            irq_s <= irq_m;
        end
    end

    // Address compare value, read-back byte and end-of-byte flag.
    always_comb begin
        own_addr  = {ADDR_HI, addr_pins};
        rd_byte   = {~irq_s, sel_q};
        byte_done = fall_i && (bit_cnt == 4'(BYTE_W));
    end

    // Protocol state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            bit_cnt       <= '0;
            rx_sh         <= '0;
            tx_sh         <= '0;
            is_read       <= 1'b0;
            ctl_acked     <= 1'b0;
            pend_sel      <= '0;
            pend_vld      <= 1'b0;
            sel_q         <= '0;
            sda_drive_low <= 1'b0;
        end else if (stop_i) begin
            state         <= ST_IDLE;
            sda_drive_low <= 1'b0;
            pend_vld      <= 1'b0;
            if (pend_vld) begin
                sel_q <= pend_sel;
            end
        end else if (start_i) begin
            state         <= ST_ADDR;
            bit_cnt       <= '0;
            sda_drive_low <= 1'b0;
        end else begin
            case (state)
                ST_ADDR: begin
                    if (rise_i) begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], sda_i};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        if (rx_sh[BYTE_W-1:1] == own_addr) begin
                            is_read       <= rx_sh[0];
                            sda_drive_low <= 1'b1;
                            state         <= ST_ADDR_ACK;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (fall_i) begin
                        bit_cnt <= '0;
                        if (is_read) begin
                            tx_sh         <= rd_byte;
                            sda_drive_low <= ~rd_byte[BYTE_W-1];
                            state         <= ST_RDATA;
                        end else begin
                            sda_drive_low <= 1'b0;
                            state         <= ST_WDATA;
                        end
                    end
                end
                ST_WDATA: begin
                    if (rise_i) begin
                        rx_sh   <= {rx_sh[BYTE_W-2:0], sda_i};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        pend_sel      <= rx_sh[NCH-1:0];
                        pend_vld      <= 1'b1;
                        sda_drive_low <= 1'b1;
                        state         <= ST_WACK;
                    end
                end
                ST_WACK: begin
                    if (fall_i) begin
                        sda_drive_low <= 1'b0;
                        bit_cnt       <= '0;
                        state         <= ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (rise_i) begin
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        sda_drive_low <= 1'b0;
                        ctl_acked     <= 1'b0;
                        state         <= ST_RACK;
                    end else if (fall_i) begin
                        sda_drive_low <= ~tx_sh[BYTE_W-2];
                        tx_sh         <= {tx_sh[BYTE_W-2:0], 1'b0};
                    end
                end
                ST_RACK: begin
                    if (rise_i) begin
                        if (sda_i) begin
                            state <= ST_SKIP;
                        end else begin
                            ctl_acked <= 1'b1;
                        end
                    end else if (fall_i && ctl_acked) begin
                        tx_sh         <= rd_byte;
                        sda_drive_low <= ~rd_byte[BYTE_W-1];
                        bit_cnt       <= '0;
                        state         <= ST_RDATA;
                    end
                end
                default: ;
            endcase
        end
    end

    // Expose applied enables and debug-visible state.
    always_comb begin
        ch_en     = sel_q;
        state_o   = state;
        bit_cnt_o = bit_cnt;
    end
endmodule

// File: rtl/chsel_i2c_target.sv
// Top of the channel-select I2C target: line filters, bus event detector
// and protocol engine. Assumes scl_in/sda_in are the pin levels and that
// sda_drive_low is wired to an open-drain pad at chip level.
module chsel_i2c_target
    import chsel_pkg::*;
#(
    parameter int                    NCH         = 4,
    parameter int                    ADDR_PIN_W  = 2,
    parameter logic [6-ADDR_PIN_W:0] ADDR_HI     = 5'b11100,
    parameter int                    FILT_CYCLES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    input  logic [ADDR_PIN_W-1:0] addr_pins,
    input  logic [NCH-1:0]        irq_n,
    output logic                  sda_drive_low,
    output logic [NCH-1:0]        ch_en
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] line_raw;
    logic [NLINES-1:0] line_clean;
    logic              scl_filt;
    logic              sda_filt;
    logic              start_evt;
    logic              stop_evt;
    logic              scl_rise;
    logic              scl_fall;
    tgt_state_e        fsm_state;
    logic [3:0]        bit_cnt;

    // Pack the bus lines so one filter is generated per line.
    always_comb begin
        line_raw = {sda_in, scl_in};
        scl_filt = line_clean[0];
        sda_filt = line_clean[1];
    end

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        chsel_line_filter #(
            .FILT_CYCLES (FILT_CYCLES)
        ) u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw_in    (line_raw[g]),
            .clean_out (line_clean[g])
        );
    end

    chsel_bus_events u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_filt),
        .sda_f   (sda_filt),
        .start_o (start_evt),
        .stop_o  (stop_evt),
        .rise_o  (scl_rise),
        .fall_o  (scl_fall)
    );

    chsel_target_fsm #(
        .NCH        (NCH),
        .ADDR_PIN_W (ADDR_PIN_W),
        .ADDR_HI    (ADDR_HI)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_evt),
        .stop_i        (stop_evt),
        .rise_i        (scl_rise),
        .fall_i        (scl_fall),
        .sda_i         (sda_filt),
        .addr_pins     (addr_pins),
        .irq_n         (irq_n),
        .ch_en         (ch_en),
        .sda_drive_low (sda_drive_low),
        .state_o       (fsm_state),
        .bit_cnt_o     (bit_cnt)
    );
endmodule

// File: rtl/chsel_i2c_checker.sv
// Protocol assertions for chsel_i2c_target, attached by bind below.
module chsel_i2c_checker
    import chsel_pkg::*;
#(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           scl_filt,
    input logic           start_evt,
    input logic           stop_evt,
    input logic           sda_drive_low,
    input logic [NCH-1:0] ch_en,
    input tgt_state_e     fsm_state,
    input logic [3:0]     bit_cnt
);
    AST_EN_CHANGE_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en != $past(ch_en)) |-> $past(stop_evt)); // R5

    AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_evt) |-> (fsm_state == ST_IDLE && !sda_drive_low)); // R10

    AST_DRIVE_ONLY_WHEN_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive_low |-> (fsm_state == ST_ADDR_ACK || fsm_state == ST_WACK
                           || fsm_state == ST_RDATA)); // R8

    AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_SKIP) |-> !sda_drive_low); // R2

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_drive_low != $past(sda_drive_low))
        |-> (!$past(scl_filt) || $past(start_evt) || $past(stop_evt))); // R1

    AST_RESTART_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_evt) |-> (fsm_state == ST_ADDR && bit_cnt == 4'd0)); // R9

    AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'(2 * NCH)); // R3
endmodule

bind chsel_i2c_target chsel_i2c_checker #(.NCH(NCH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_filt      (scl_filt),
    .start_evt     (start_evt),
    .stop_evt      (stop_evt),
    .sda_drive_low (sda_drive_low),
    .ch_en         (ch_en),
    .fsm_state     (fsm_state),
    .bit_cnt       (bit_cnt)
);

// File: tb/chsel_i2c_target_tb.sv
module chsel_i2c_target_tb;
    localparam int         Q      = 8;           // clocks per quarter bit
    localparam logic [4:0] HI_ADR = 5'b11100;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       m_scl;
    logic       m_sda;
    logic [1:0] addr_pins;
    logic [3:0] irq_n;
    logic       sda_drive_low;
    logic [3:0] ch_en;
    logic       sda_line;
    int         n_tests = 0;
    int         n_fail  = 0;
    logic [3:0] exp_ch;
    logic       ack_a;
    logic       ack_d;
    logic [7:0] rb;
    logic       s;

    always #4 clk = ~clk;
    assign sda_line = m_sda & ~sda_drive_low;

    chsel_i2c_target u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (m_scl),
        .sda_in        (sda_line),
        .addr_pins     (addr_pins),
        .irq_n         (irq_n),
        .sda_drive_low (sda_drive_low),
        .ch_en         (ch_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; qw();
        m_sda = 1'b0; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b0; qw();
        m_scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw();
        m_scl = 1'b1; qw();
        m_sda = 1'b1; qw();
    endtask

    // One clock: optional short spikes on SCL (low phase) and SDA (high phase).
    task automatic bit_io(input logic b, input logic glitch, output logic smp);
        m_sda = b;
        if (glitch) begin
            repeat (2) @(negedge clk);
            m_scl = 1'b1;
            repeat (2) @(negedge clk);
            m_scl = 1'b0;
            repeat (Q - 4) @(negedge clk);
        end else begin
            qw();
        end
        m_scl = 1'b1;
        qw();
        smp = sda_line;
        if (glitch && b) begin
            m_sda = 1'b0;
            repeat (2) @(negedge clk);
            m_sda = 1'b1;
            repeat (Q - 2) @(negedge clk);
        end else begin
            qw();
        end
        m_scl = 1'b0;
        qw();
    endtask

    task automatic send_byte(input logic [7:0] d, input logic glitch, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) bit_io(d[i], glitch, x);
        bit_io(1'b1, 1'b0, x);
        ack = ~x;
    endtask

    task automatic recv_byte(input logic give_ack, input logic [3:0] irq_next,
                             output logic [7:0] d);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, 1'b0, x);
            d[i] = x;
        end
        irq_n = irq_next;
        bit_io(~give_ack, 1'b0, x);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
        addr_pins = 2'b00; irq_n = 4'hF; exp_ch = 4'h0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        qw();
        chk("R10 reset ch_en", {4'h0, ch_en}, 8'h00);
        chk("R10 reset sda", {7'h0, sda_line}, 8'h01);

        // R1/R2: every strap against every sent low address pair
        for (int p = 0; p < 4; p++) begin
            for (int l = 0; l < 4; l++) begin
                logic [3:0] v;
                v = 4'(p * 4 + l);
                addr_pins = 2'(p);
                qw();
                bus_start();
                send_byte({HI_ADR, 2'(l), 1'b0}, 1'b0, ack_a);
                send_byte({~v, v}, 1'b0, ack_d);
                bus_stop();
                qw();
                if (p == l) begin
                    exp_ch = v;
                    chk("R1 addr ack", {7'h0, ack_a}, 8'h01);
                    chk("R8 data ack", {7'h0, ack_d}, 8'h01);
                end else begin
                    chk("R2 mismatch no ack", {6'h0, ack_a, ack_d}, 8'h00);
                end
                chk("R2/R3 ch_en after stop", {4'h0, ch_en}, {4'h0, exp_ch});
            end
        end

        // R3/R4/R5/R6: all channel patterns, scrambled upper nibble, read back
        addr_pins = 2'b10;
        for (int v = 0; v < 16; v++) begin
            logic [3:0] w;
            logic [3:0] iq;
            w = 4'(v);
            iq = {w[0], w[3:1]};
            bus_start();
            send_byte({HI_ADR, 2'b10, 1'b0}, 1'b0, ack_a);
            send_byte({w ^ 4'h9, w}, 1'b0, ack_d);
            chk("R8 write ack", {6'h0, ack_a, ack_d}, 8'h03);
            chk("R5 held mid-transfer", {4'h0, ch_en}, {4'h0, exp_ch});
            bus_stop();
            qw();
            exp_ch = w;
            chk("R3 R4 ch_en", {4'h0, ch_en}, {4'h0, w});
            irq_n = iq;
            qw();
            bus_start();
            send_byte({HI_ADR, 2'b10, 1'b1}, 1'b0, ack_a);
            recv_byte(1'b0, iq, rb);
            bus_stop();
            qw();
            chk("R6 read byte", rb, {~iq, w});
        end

        // R3: several bytes in one write, last one kept
        bus_start();
        send_byte({HI_ADR, 2'b10, 1'b0}, 1'b0, ack_a);
        send_byte(8'h03, 1'b0, ack_d);
        send_byte(8'h0C, 1'b0, ack_d);
        send_byte(8'hFA, 1'b0, ack_d);
        bus_stop();
        qw();
        exp_ch = 4'hA;
        chk("R3 last byte kept", {4'h0, ch_en}, 8'h0A);

        // R7: acked read refreshes status, nack releases SDA
        irq_n = 4'hE;
        qw();
        bus_start();
        send_byte({HI_ADR, 2'b10, 1'b1}, 1'b0, ack_a);
        recv_byte(1'b1, 4'h3, rb);
        chk("R7 first byte", rb, 8'h1A);
        recv_byte(1'b0, 4'h3, rb);
        chk("R7 second byte fresh status", rb, 8'hCA);
        bit_io(1'b1, 1'b0, s);
        chk("R7 released after nack", {7'h0, s}, 8'h01);
        bus_stop();
        qw();

        // R9/R5: write, repeated start, read shows old enables until stop
        bus_start();
        send_byte({HI_ADR, 2'b10, 1'b0}, 1'b0, ack_a);
        send_byte(8'h05, 1'b0, ack_d);
        bus_rstart();
        send_byte({HI_ADR, 2'b10, 1'b1}, 1'b0, ack_a);
        chk("R9 restart addr ack", {7'h0, ack_a}, 8'h01);
        recv_byte(1'b0, 4'h3, rb);
        chk("R9 R5 read before stop", rb, 8'hCA);
        bus_stop();
        qw();
        exp_ch = 4'h5;
        chk("R5 applied at stop", {4'h0, ch_en}, 8'h05);

        // R11: spikes on SCL and SDA are filtered
        bus_start();
        send_byte({HI_ADR, 2'b10, 1'b0}, 1'b1, ack_a);
        send_byte(8'h96, 1'b1, ack_d);
        bus_stop();
        qw();
        chk("R11 glitch acks", {6'h0, ack_a, ack_d}, 8'h03);
        chk("R11 glitch data", {4'h0, ch_en}, 8'h06);

        // R10: reset in the middle of an acknowledge
        bus_start();
        send_byte({HI_ADR, 2'b10, 1'b0}, 1'b0, ack_a);
        for (int i = 7; i >= 0; i--) bit_io(1'b0, 1'b0, s);
        m_sda = 1'b1;
        repeat (Q + 2) @(negedge clk);
        chk("R8 driving ack before reset", {7'h0, sda_drive_low}, 8'h01);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 reset ch_en", {4'h0, ch_en}, 8'h00);
        chk("R10 reset sda release", {7'h0, sda_line}, 8'h01);
        m_scl = 1'b1;
        qw();
        rst_n = 1'b1;
        qw();
        bus_start();
        send_byte({HI_ADR, 2'b10, 1'b0}, 1'b0, ack_a);
        send_byte(8'h09, 1'b0, ack_d);
        bus_stop();
        qw();
        chk("R10 works after reset", {4'h0, ch_en}, 8'h09);

        summary();
    end
endmodule